// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits behind a UART receiver that hands over 9-bit characters. The ninth bit of each character tells an address byte from a data byte. The filter holds a node address and a 2-bit mode field. From these it decides, one character at a time, whether the byte reaches the host data port and whether it raises an interrupt. In the filtering modes it also marks the first data byte of each accepted frame with a new-frame flag. A frame is an address byte followed by the data bytes that come after it.

The mode field selects one of four behaviours:
- **Pass-all (00):** every character is delivered.
- **Software-assisted (01):** every address byte is delivered, and software can silence the rest of the current frame.
- **Hardware filter (10):** only frames whose address matches are delivered, and the matching address byte is delivered too.
- **Quiet hardware filter (11):** the same as the hardware filter, except that the address byte is never delivered.

Delivery is a single-cycle strobe that carries the byte and the new-frame flag. An interrupt pulse comes in the same cycle.

A four-state machine tracks frames:
- **HUNT:** no accepted frame. This is the state after reset.
- **FIRST:** a matching address has arrived and no data byte has followed it yet.
- **BODY:** inside an accepted frame, after its first data byte.
- **MUTED:** software has silenced the current frame.

The transitions are:
- An address byte in the filter modes moves to FIRST on a match and to HUNT on a mismatch.
- An address byte in pass-all or software-assisted mode moves to BODY.
- A data byte moves FIRST to BODY.
- A mute request in software-assisted mode moves to MUTED. An address byte in the same cycle takes priority over the mute request.

Top module: `mp_addr_filter`

## Requirements
- R1: A character is an address byte when `rx_addr` is 1. It matches when its 8 data bits equal `node_addr`. In mode 10, a matching address byte is delivered with `dout` equal to the address and `new_frame` equal to 0.
- R2: In modes 10 and 11, an address byte that does not match is dropped. Every data byte after it is also dropped, until the next address byte arrives.
- R3: In modes 10 and 11, each data byte of an accepted frame is delivered with an interrupt.
- R4: In modes 10 and 11, `new_frame` is 1 on the first data byte after a matching address and 0 on the later data bytes of that frame. It is 0 whenever `dv` is 0.
- R5: Every address byte is compared again. A mismatch in the middle of a frame closes that frame. A later match opens a new frame, and the first data byte of that frame carries `new_frame` equal to 1.
- R6: In mode 11, an address byte never produces `dv` or `irq`, whether or not it matches. Data handling is the same as in mode 10.
- R7: In mode 00, every character is delivered with an interrupt and with `new_frame` equal to 0.
- R8: In mode 01:
  - Every address byte is delivered, and so is every data byte that follows it.
  - A `sw_mute` pulse drops every later data byte until the next address byte.
  - An address byte that arrives in the same cycle as `sw_mute` wins, and the frame stays open.
  - A data byte that arrives in the same cycle as `sw_mute` is still delivered.
- R9: After reset, `dv`, `irq` and `new_frame` are 0 and `dout` is 0. The filter is in HUNT, so in modes 10, 11 and 01, data bytes are dropped until an address byte opens a frame.
- R10: `dv`, `irq`, `dout` and `new_frame` update one clock after the `rx_stb` cycle they answer. `dv` and `irq` are single-cycle pulses that occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Low 8 bits of the received character |
| rx_addr | input | 1 | Ninth bit: 1 marks an address byte |
| mode | input | 2 | Filter mode (00 pass-all, 01 software, 10 filter, 11 quiet filter) |
| node_addr | input | 8 | Node address compared against address bytes |
| sw_mute | input | 1 | Software request to drop the rest of the frame (mode 01) |
| dv | output | 1 | Data-valid strobe for the host port |
| dout | output | 8 | Delivered byte |
| new_frame | output | 1 | Set on the first data byte of an accepted frame |
| irq | output | 1 | Interrupt pulse, coincident with `dv` |

## Verification
The filter modes are driven with several frame sequences:
- Matching and non-matching addresses are interleaved, which separates "frame dropped" from "frame closed by re-compare".
- Two matching addresses are sent back to back, with no data byte between them.
- Characters arrive on consecutive cycles, as well as with idle gaps between them.

In pass-all mode, the bench checks that filtering state has no effect on delivery. Software-assisted mode is run with mute pulses placed in an idle cycle, alongside a data byte, and alongside an address byte; this separates the three mute priorities. Mode changes between sequences show that the state machine carries frame state across a mode change.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    typedef enum logic [1:0] {
        MD_OPEN     = 2'b00,
        MD_SOFT     = 2'b01,
        MD_HW       = 2'b10,
        MD_HW_QUIET = 2'b11
    } mpf_mode_e;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FIRST = 2'd1,
        ST_BODY  = 2'd2,
        ST_MUTED = 2'd3
    } mpf_state_e;

endpackage

// File: rtl/mpf_addr_cmp.sv
module mpf_addr_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] char_bits,
    input  logic [DW-1:0] node_bits,
    output logic          hit
);
    logic [DW-1:0] bit_eq;

    for (genvar i = 0; i < DW; i++) begin : g_eq
        assign bit_eq[i] = char_bits[i] ~^ node_bits[i];
    end

    assign hit = &bit_eq;
endmodule

// File: rtl/mpf_fsm.sv
module mpf_fsm
    import mpf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_stb,
    input  logic       rx_addr,
    input  logic       hit,
    input  logic [1:0] mode,
    input  logic       sw_mute,
    output logic       take,
    output logic       take_nf,
    output mpf_state_e state
);
    mpf_state_e nxt;
    mpf_mode_e  md;

    assign md = mpf_mode_e'(mode);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (rx_stb && rx_addr) begin
            unique case (md)
                MD_OPEN, MD_SOFT:   nxt = ST_BODY;
                MD_HW, MD_HW_QUIET: nxt = hit ? ST_FIRST : ST_HUNT;
            endcase
        end else begin
            if (rx_stb && state == ST_FIRST) nxt = ST_BODY;
            if (md == MD_SOFT && sw_mute)    nxt = ST_MUTED;
        end
    end

    // delivery decision
    always_comb begin
        take    = 1'b0;
        take_nf = 1'b0;
        if (rx_stb) begin
            if (rx_addr) begin
                unique case (md)
                    MD_OPEN, MD_SOFT: take = 1'b1;
                    MD_HW:            take = hit;
                    MD_HW_QUIET:      take = 1'b0;
                endcase
            end else if (md == MD_OPEN) begin
                take = 1'b1;
            end else begin
                unique case (state)
                    ST_FIRST: begin
                        take    = 1'b1;
                        take_nf = 1'b1;
                    end
                    ST_BODY:            take = 1'b1;
                    ST_HUNT, ST_MUTED:  take = 1'b0;
                endcase
            end
        end
    end

    // R2: a mismatching address in a filter mode returns the machine to HUNT
    p_mismatch_hunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && rx_addr && mode[1] && !hit) |=> (state == ST_HUNT));

    // R5: a matching address in a filter mode always opens a fresh frame
    p_match_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && rx_addr && mode[1] && hit) |=> (state == ST_FIRST));
endmodule

// File: rtl/mpf_out_reg.sv
module mpf_out_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          take_nf,
    input  logic [DW-1:0] char_bits,
    output logic          dv,
    output logic [DW-1:0] dout,
    output logic          new_frame,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv        <= 1'b0;
            irq       <= 1'b0;
            new_frame <= 1'b0;
            dout      <= '0;
        end else begin
            dv        <= take;
            irq       <= take;
            new_frame <= take & take_nf;
            if (take) dout <= char_bits;
        end
    end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
    import mpf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_stb,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_addr,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] node_addr,
    input  logic          sw_mute,
    output logic          dv,
    output logic [DW-1:0] dout,
    output logic          new_frame,
    output logic          irq
);
    logic       hit;
    logic       take;
    logic       take_nf;
    mpf_state_e state;

    mpf_addr_cmp #(.DW(DW)) u_cmp (
        .char_bits (rx_data),
        .node_bits (node_addr),
        .hit       (hit)
    );

    mpf_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_stb  (rx_stb),
        .rx_addr (rx_addr),
        .hit     (hit),
        .mode    (mode),
        .sw_mute (sw_mute),
        .take    (take),
        .take_nf (take_nf),
        .state   (state)
    );

    mpf_out_reg #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .take_nf   (take_nf),
        .char_bits (rx_data),
        .dv        (dv),
        .dout      (dout),
        .new_frame (new_frame),
        .irq       (irq)
    );

    // R10: every delivery answers a strobe one cycle earlier
    p_dv_after_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dv |-> $past(rx_stb));

    // R4: the new-frame flag only rides on a delivery, and only in filter modes
    p_nf_in_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        new_frame |-> (dv && $past(mode[1])));

    // R6: quiet mode never delivers an address byte
    p_quiet_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && rx_addr && mode == 2'b11) |=> !dv);

    // R7: pass-all mode delivers every character
    p_pass_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && mode == 2'b00) |=> (dv && irq));

    // R8: a muted frame drops its data bytes
    p_muted_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUTED && rx_stb && !rx_addr && mode == 2'b01) |=> !dv);
endmodule

// File: tb/sim_mp_addr_filter.sv
module sim_mp_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_stb = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_addr = 1'b0;
    logic [1:0] mode = 2'b10;
    logic [7:0] node_addr = 8'h5A;
    logic       sw_mute = 1'b0;
    logic       dv, new_frame, irq;
    logic [7:0] dout;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R9";

    // behavioural reference
    int       m_st = 0;   // 0 hunt, 1 first, 2 body, 3 muted
    bit       e_dv = 0, e_nf = 0;
    bit [7:0] e_dout = 0;

    always #5 clk = ~clk;

    mp_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_data(rx_data),
        .rx_addr(rx_addr), .mode(mode), .node_addr(node_addr),
        .sw_mute(sw_mute), .dv(dv), .dout(dout), .new_frame(new_frame),
        .irq(irq)
    );

    always @(posedge clk) begin
        bit go, nf;
        go = 0; nf = 0;
        if (!rst_n) begin
            m_st = 0; e_dout = 0;
        end else begin
            if (rx_stb && rx_addr) begin
                if (mode == 2'd0 || mode == 2'd1) begin
                    go = 1; m_st = 2;
                end else begin
                    go = (mode == 2'd2) && (rx_data == node_addr);
                    m_st = (rx_data == node_addr) ? 1 : 0;
                end
            end else begin
                if (rx_stb) begin
                    if (mode == 2'd0) go = 1;
                    else if (m_st == 1) begin go = 1; nf = 1; end
                    else if (m_st == 2) go = 1;
                    if (m_st == 1) m_st = 2;
                end
                if (mode == 2'd1 && sw_mute) m_st = 3;
            end
            if (go) e_dout = rx_data;
        end
        e_dv = go; e_nf = nf;
    end

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("dv", dv, e_dv);
            chk("irq", irq, e_dv);
            chk("new_frame", new_frame, e_nf);
            chk("dout", dout, e_dout);
        end
    end

    task automatic put(bit a, bit [7:0] d, bit mute = 0);
        @(posedge clk); #2;
        rx_stb = 1; rx_addr = a; rx_data = d; sw_mute = mute;
        @(posedge clk); #2;
        rx_stb = 0; sw_mute = 0;
    endtask

    task automatic burst(bit a, bit [7:0] d);
        @(posedge clk); #2;
        rx_stb = 1; rx_addr = a; rx_data = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            rx_stb = 0; sw_mute = 0;
        end
    endtask

    task automatic mute_only();
        @(posedge clk); #2; sw_mute = 1;
        @(posedge clk); #2; sw_mute = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        cur_req = "R9";
        chk("reset dv", dv, 0); chk("reset irq", irq, 0);
        chk("reset nf", new_frame, 0); chk("reset dout", dout, 0);
        // R9: data before any address is dropped
        put(0, 8'h11); put(0, 8'h12);

        cur_req = "R1"; put(1, 8'h5A);
        cur_req = "R4"; put(0, 8'hA0); put(0, 8'hA1);
        cur_req = "R3"; put(0, 8'hA2);
        cur_req = "R2"; put(1, 8'h5B); put(0, 8'hB0); put(0, 8'hB1);
        cur_req = "R5"; put(1, 8'h5A); put(1, 8'h5A); put(0, 8'hC0); put(0, 8'hC1);
        put(1, 8'h00); put(0, 8'hC2);
        // consecutive-cycle stream
        cur_req = "R10";
        burst(1, 8'h5A); burst(0, 8'hD0); burst(0, 8'hD1); burst(1, 8'h77);
        burst(0, 8'hD2); burst(1, 8'h5A); burst(0, 8'hD3); idle(3);

        cur_req = "R6"; mode = 2'b11;
        put(1, 8'h5A); put(0, 8'hE0); put(0, 8'hE1); put(1, 8'h33); put(0, 8'hE2);
        put(1, 8'h5A); put(0, 8'hE3);
        node_addr = 8'hC3; put(1, 8'hC3); put(0, 8'hE4);

        cur_req = "R7"; mode = 2'b00;
        put(1, 8'h01); put(0, 8'hF0); put(1, 8'h5A); put(0, 8'hF1);
        burst(0, 8'hF2); burst(1, 8'h99); idle(2);

        cur_req = "R8"; mode = 2'b01;
        put(1, 8'h42); put(0, 8'h80); mute_only(); put(0, 8'h81); put(0, 8'h82);
        put(1, 8'h43); put(0, 8'h83);
        put(0, 8'h84, 1); put(0, 8'h85);
        put(1, 8'h44, 1); put(0, 8'h86);

        cur_req = "R2"; mode = 2'b10; node_addr = 8'h5A;
        put(0, 8'h90);
        put(1, 8'h5A); put(0, 8'h91);
        idle(3);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule